// File: doc/BRIEF.md
# Two-Wire Bus Target with Flow Control

This block is a target on a two-wire serial bus (a clock line and a data line, both open-drain). It watches both lines through synchronisers and a glitch filter, finds START and STOP conditions, and collects the 7-bit address that follows a START. When the address equals its fixed `TARGET_ADDR` parameter it acknowledges. It then either receives bytes from the master or sends bytes to it, depending on the direction bit.

Received bytes go into a small receive FIFO that local logic drains. Bytes to send are taken from a transmit FIFO that local logic fills. The block applies back-pressure in two ways. It refuses a written byte with a not-acknowledge when the receive FIFO has no room. It holds the clock line low when a read byte is due and the transmit FIFO is empty. The outputs `sda_oe` and `scl_oe` are pull-down enables: when an enable is 1 the pad drives that line low.

Top module: `twi_target`

## Requirements
- R1: After a START, a 7-bit address equal to `TARGET_ADDR` (sent MSB first) is acknowledged: SDA is low while SCL is high on the ninth clock. The direction bit that follows the address is 0 for a write and 1 for a read.
- R2: A non-matching address gets no acknowledge. The block keeps SDA released and stores nothing until the next START.
- R3: On a write, each data byte is acknowledged while the receive FIFO has room. Bytes appear on `rx_data` in arrival order, and each byte is assembled MSB first.
- R4: A write byte that arrives while the receive FIFO is full is refused with a not-acknowledge (SDA high on the ninth clock) and is dropped. Every later bit up to the next START or STOP is also left unacknowledged.
- R5: On a read, the block drives the eight bits of each transmit-FIFO byte MSB first, and keeps SDA released during the acknowledge bit that the master drives.
- R6: A master acknowledge (SDA low) makes the block send the next FIFO byte. A master not-acknowledge makes the block stop driving. Any further clocks read back as 1, and no further byte is taken from the transmit FIFO.
- R7: If the transmit FIFO is empty when a read byte is due, `scl_oe` holds SCL low. It is released once a byte has been written, and that byte is then sent.
- R8: A repeated START in the middle of a transfer returns the block to address reception, and the new direction bit takes effect.
- R9: After reset, `sda_oe`, `scl_oe`, `rx_valid` and `tx_full` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled level of the clock line |
| sda_i | input | 1 | Sampled level of the data line |
| scl_oe | output | 1 | Pull the clock line low (stretch) |
| sda_oe | output | 1 | Pull the data line low |
| rx_rd | input | 1 | Pop one byte from the receive FIFO |
| rx_data | output | 8 | Oldest received byte |
| rx_valid | output | 1 | Receive FIFO holds at least one byte |
| tx_wr | input | 1 | Push `tx_data` into the transmit FIFO |
| tx_data | input | 8 | Byte to queue for reads |
| tx_full | output | 1 | Transmit FIFO has no free entry |

## Verification
A bit-level master model drives the bus through open-drain wiring that includes the block's own pull-downs. It runs five kinds of traffic:
- Writes with irregular bit patterns and a matching address check ACK and byte order.
- Writes past the receive depth tell a full-FIFO refusal apart from an address refusal.
- A foreign address confirms that the block stays silent.
- Reads ended by ACK and then by NACK show whether the transmit FIFO is popped only on demand.
- A read with an empty FIFO, and a write turned into a read by a repeated START, separate clock stretching and restart handling from plain transfers.

// File: rtl/twi_target_pkg.sv
package twi_target_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RLOAD,
    ST_RD,
    ST_RACK,
    ST_HOLD
  } twi_state_e;
endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [1:0]     sync;
  logic [LEN-1:0] hist;

  // two-stage synchroniser, then the output follows only a stable run of LEN samples
  always_ff @(posedge clk) begin
    if (rst) begin
      sync <= 2'b11;
      hist <= '1;
      dout <= 1'b1;
    end else begin
      sync <= {sync[0], din};
      hist <= {hist[LEN-2:0], sync[1]};
      if (&hist)       dout <= 1'b1;
      else if (~|hist) dout <= 1'b0;
    end
  end
endmodule

// File: rtl/twi_fifo.sv
module twi_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  // DEPTH is a power of two so the pointers wrap on their own
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign empty   = (cnt == '0);
  assign full    = (cnt == FULL_CNT);
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/twi_engine.sv
module twi_engine
  import twi_target_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_f,
  input  logic              sda_f,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_full,
  output logic              tx_pop,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_empty,
  output logic              sda_oe,
  output logic              scl_oe
);
  twi_state_e        state;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] shreg;
  logic              rw, mack;
  logic              scl_q, sda_q;
  logic              rise, fall, start_c, stop_c;

  assign rise    = !scl_q && scl_f;
  assign fall    = scl_q && !scl_f;
  assign start_c = scl_q && scl_f && sda_q && !sda_f;
  assign stop_c  = scl_q && scl_f && !sda_q && sda_f;
  assign rx_byte = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
      scl_oe  <= 1'b0;
      rx_push <= 1'b0;
      tx_pop  <= 1'b0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
    end else begin
      scl_q   <= scl_f;
      sda_q   <= sda_f;
      rx_push <= 1'b0;
      tx_pop  <= 1'b0;
      if (start_c) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else if (stop_c) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WR: begin
            if (rise) begin
              shreg <= {shreg[BYTE_W-2:0], sda_f};
              cnt   <= cnt + 1'b1;
            end else if (fall && cnt == 4'd8) begin
              if (state == ST_ADDR) begin
                if (shreg[7:1] == TARGET_ADDR) begin
                  sda_oe <= 1'b1;
                  rw     <= shreg[0];
                  state  <= ST_AACK;
                end else begin
                  state <= ST_HOLD;
                end
              end else if (!rx_full) begin
                rx_push <= 1'b1;
                sda_oe  <= 1'b1;
                state   <= ST_WACK;
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          ST_AACK, ST_WACK: begin
            if (fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              if (state == ST_AACK && rw) begin
                scl_oe <= tx_empty;
                state  <= ST_RLOAD;
              end else begin
                state <= ST_WR;
              end
            end
          end
          ST_RLOAD: begin
            if (!tx_empty) begin
              shreg  <= tx_byte;
              tx_pop <= 1'b1;
              sda_oe <= !tx_byte[7];
              scl_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_RD;
            end
          end
          ST_RD: begin
            if (fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                cnt    <= cnt + 1'b1;
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe <= !shreg[6];
              end
            end
          end
          ST_RACK: begin
            if (rise) begin
              mack <= !sda_f;
            end else if (fall) begin
              if (mack) begin
                scl_oe <= tx_empty;
                state  <= ST_RLOAD;
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_target.sv
module twi_target
  import twi_target_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h2A,
  parameter int         RX_DEPTH    = 4,
  parameter int         TX_DEPTH    = 4,
  parameter int         FILT_LEN    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              rx_rd,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              tx_wr,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_full
);
  logic              scl_f, sda_f;
  logic              rx_push, rx_full, rx_empty;
  logic [BYTE_W-1:0] rx_byte;
  logic              tx_pop, tx_empty;
  logic [BYTE_W-1:0] tx_byte;

  twi_line_filter #(.LEN(FILT_LEN)) u_scl_filt (
    .clk(clk), .rst(rst), .din(scl_i), .dout(scl_f)
  );
  twi_line_filter #(.LEN(FILT_LEN)) u_sda_filt (
    .clk(clk), .rst(rst), .din(sda_i), .dout(sda_f)
  );

  twi_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk(clk), .rst(rst), .push(rx_push), .din(rx_byte),
    .pop(rx_rd), .dout(rx_data), .empty(rx_empty), .full(rx_full)
  );
  twi_fifo #(.W(BYTE_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk(clk), .rst(rst), .push(tx_wr), .din(tx_data),
    .pop(tx_pop), .dout(tx_byte), .empty(tx_empty), .full(tx_full)
  );

  twi_engine #(.TARGET_ADDR(TARGET_ADDR)) u_engine (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f),
    .rx_push(rx_push), .rx_byte(rx_byte), .rx_full(rx_full),
    .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_empty(tx_empty),
    .sda_oe(sda_oe), .scl_oe(scl_oe)
  );

  assign rx_valid = !rx_empty;
endmodule

// File: rtl/twi_target_chk.sv
module twi_target_chk (
  input logic clk,
  input logic rst,
  input logic scl_f,
  input logic sda_oe,
  input logic scl_oe,
  input logic rx_push,
  input logic rx_full,
  input logic tx_pop,
  input logic tx_empty
);
  // data line is only ever taken low during the clock low phase
  assert_sda_drive_in_low_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_f);

  // a push never reaches a full receive FIFO
  assert_no_rx_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> !rx_full);

  // a transmit byte is consumed only while the clock is low
  assert_tx_pop_low_R5: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> !scl_f);

  // stretch ends only after a byte became available
  assert_stretch_release_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_oe) |-> $past(!tx_empty));

  // no data drive while the clock is being held
  assert_no_sda_while_stretch_R7: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> !sda_oe);
endmodule

bind twi_target twi_target_chk u_chk (
  .clk(clk), .rst(rst), .scl_f(scl_f), .sda_oe(sda_oe), .scl_oe(scl_oe),
  .rx_push(rx_push), .rx_full(rx_full), .tx_pop(tx_pop), .tx_empty(tx_empty)
);

// File: tb/sim_twi_target.sv
`timescale 1ns/1ps
module sim_twi_target;
  localparam logic [6:0] ADDR = 7'h2A;
  localparam int H = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, scl_bus, sda_bus;
  logic rx_rd = 1'b0, rx_valid, tx_wr = 1'b0, tx_full;
  logic [7:0] rx_data, tx_data = 8'h00;
  int checks = 0, failures = 0, cyc = 0;
  logic [7:0] exp_rx [$];

  always #10 clk = ~clk;

  assign scl_bus = scl_m & ~scl_oe;
  assign sda_bus = sda_m & ~sda_oe;

  twi_target u0 (
    .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_rd(rx_rd), .rx_data(rx_data),
    .rx_valid(rx_valid), .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b, output logic seen, output logic oe_seen);
    wclk(H/2); sda_m = b; wclk(H/2);
    scl_m = 1'b1;
    while (scl_bus == 1'b0) @(negedge clk);
    wclk(H/2); seen = sda_bus; oe_seen = sda_oe; wclk(H/2);
    scl_m = 1'b0;
  endtask

  task automatic m_start();
    wclk(H/2); sda_m = 1'b1; wclk(H/2); scl_m = 1'b1; wclk(H);
    sda_m = 1'b0; wclk(H); scl_m = 1'b0;
  endtask

  task automatic m_stop();
    wclk(H/2); sda_m = 1'b0; wclk(H/2); scl_m = 1'b1; wclk(H);
    sda_m = 1'b1; wclk(H);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack_low);
    logic s, o;
    for (int i = 7; i >= 0; i--) put_bit(b[i], s, o);
    put_bit(1'b1, s, o);
    ack_low = !s;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b, output logic oe_in_ack);
    logic s, o;
    for (int i = 7; i >= 0; i--) begin
      put_bit(1'b1, s, o);
      b[i] = s;
    end
    put_bit(!give_ack, s, o);
    oe_in_ack = o;
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic drain_rx(input string req);
    while (rx_valid) begin
      logic [7:0] e;
      e = (exp_rx.size() > 0) ? exp_rx.pop_front() : 8'hxx;
      chk(rx_data === e, req, rx_data, e);
      rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0; @(negedge clk);
    end
    chk(exp_rx.size() == 0, req, exp_rx.size(), 0);
  endtask

  initial begin
    logic a, o;
    logic [7:0] d;
    wclk(5); rst = 1'b0; wclk(2);
    // R9 reset state
    chk(!sda_oe && !scl_oe && !rx_valid && !tx_full, "R9", {sda_oe, scl_oe, rx_valid, tx_full}, 0);

    // R1 R3 write three bytes
    m_start(); wr_byte({ADDR, 1'b0}, a);
    chk(a, "R1 addr ack", a, 1);
    foreach (exp_rx[i]) ;
    begin
      logic [7:0] pat [3] = '{8'hA5, 8'h01, 8'hF0};
      foreach (pat[i]) begin
        wr_byte(pat[i], a);
        chk(a, "R3 data ack", a, 1);
        exp_rx.push_back(pat[i]);
      end
    end
    m_stop(); wclk(10);
    drain_rx("R3 order");

    // R4 fill receive FIFO then overflow
    m_start(); wr_byte({ADDR, 1'b0}, a);
    for (int i = 0; i < 5; i++) begin
      wr_byte(8'h30 + 8'(i), a);
      if (i < 4) begin
        chk(a, "R4 ack with room", a, 1);
        exp_rx.push_back(8'h30 + 8'(i));
      end else begin
        chk(!a, "R4 nack when full", a, 0);
      end
    end
    wr_byte(8'h77, a);
    chk(!a, "R4 ignored after nack", a, 0);
    m_stop(); wclk(10);
    drain_rx("R4 stored");

    // R2 foreign address
    m_start(); wr_byte({7'h15, 1'b0}, a);
    chk(!a, "R2 no addr ack", a, 0);
    wr_byte(8'h00, a);
    chk(!a, "R2 no data ack", a, 0);
    m_stop(); wclk(10);
    chk(!rx_valid, "R2 nothing stored", rx_valid, 0);

    // R5 R6 read with ack then nack
    push_tx(8'h96); push_tx(8'h3C); push_tx(8'hE1);
    m_start(); wr_byte({ADDR, 1'b1}, a);
    chk(a, "R1 read addr ack", a, 1);
    rd_byte(1'b1, d, o);
    chk(d == 8'h96, "R5 first byte", d, 8'h96);
    chk(!o, "R5 released in ack", o, 0);
    rd_byte(1'b0, d, o);
    chk(d == 8'h3C, "R6 next after ack", d, 8'h3C);
    rd_byte(1'b1, d, o);
    chk(d == 8'hFF, "R6 released after nack", d, 8'hFF);
    m_stop();
    m_start(); wr_byte({ADDR, 1'b1}, a);
    rd_byte(1'b0, d, o);
    chk(d == 8'hE1, "R6 byte kept", d, 8'hE1);
    m_stop();

    // R7 stretch on empty transmit FIFO
    m_start(); wr_byte({ADDR, 1'b1}, a);
    wclk(200);
    chk(scl_oe && !scl_bus, "R7 stretch held", scl_oe, 1);
    push_tx(8'h5A); wclk(20);
    chk(!scl_oe, "R7 stretch released", scl_oe, 0);
    rd_byte(1'b0, d, o);
    chk(d == 8'h5A, "R7 byte after stretch", d, 8'h5A);
    m_stop();

    // R8 repeated start switches to read
    push_tx(8'hC3);
    m_start(); wr_byte({ADDR, 1'b0}, a);
    wr_byte(8'h69, a);
    exp_rx.push_back(8'h69);
    chk(a, "R8 write before restart", a, 1);
    m_start(); wr_byte({ADDR, 1'b1}, a);
    chk(a, "R8 addr after restart", a, 1);
    rd_byte(1'b0, d, o);
    chk(d == 8'hC3, "R8 read after restart", d, 8'hC3);
    m_stop(); wclk(10);
    drain_rx("R8 written byte");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule